// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block gets an I2C bus back to idle when a target device is stuck holding SDA low. A start request makes it take the two bus pins away from the normal I2C engine. While it runs it keeps that engine in reset and masks its interrupts. Both pin outputs are set to the released level. SCL is then the only line the block drives, as an open-drain pull-down, and SDA stays an input.

The sequencer sends SCL pulses. Each pulse pulls SCL low for one timed phase and then releases it for a second timed phase. At the end of each released phase it samples both synchronised line levels. It stops as soon as SDA and SCL both read high, and it gives up after nine pulses. In either case it hands the pins back, releases the engine reset and gives a one-cycle re-initialise request together with a done pulse.

A success flag records how the run ended. A stuck-SCL flag records that SCL read low when the run was accepted. The phase length comes from the clock frequency parameter, so each phase lasts at least 10 µs.

Top module: `i2c_bus_clear`

## Requirements
- R1: When a start is accepted, `sclStuck` takes the inverse of the synchronised SCL level. The run goes ahead even when SCL is low, and the flag holds its value until the next accepted start.
- R2: While `busy` is 1, `pinSel`, `engReset` and `irqMask` are all 1. While the block is idle, all three are 0 and `sclDrvLow` is 0.
- R3: `sdaDrvLow` stays 0 at all times. SCL is only ever pulled low (`sclDrvLow`=1) or released, and each pulse is one pulled-low phase followed by one released phase.
- R4: A run produces at most 9 SCL pulses (MAX_PULSES).
- R5: Every pulled-low phase lasts exactly PHASE_CYC cycles, and so does every released phase. PHASE_CYC = ceil(CLK_FREQ_HZ × PHASE_US / 10^6) with PHASE_US = 10.
- R6: At the end of each released phase the block samples the synchronised lines as a 2-bit vector {SDA, SCL} (SCL in bit 0). If the vector equals 2'b11, no further pulse is sent. At least one pulse is always sent.
- R7: A run ends with `done` and `reinitReq` both high for exactly one cycle. In that cycle `busy`, `pinSel`, `engReset` and `irqMask` are already 0.
- R8: `success` becomes 1 when a run stops on the both-high test and 0 when all 9 pulses are used without it. The value holds until the next accepted start.
- R9: A start request while `busy` or `done` is 1 is ignored: it neither restarts nor extends the run and triggers no later run.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start a recovery run (taken only when idle) |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sclDrvLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaDrvLow | output | 1 | SDA pull-down, always 0 |
| pinSel | output | 1 | 1 = pins owned by the sequencer, 0 = I2C engine |
| engReset | output | 1 | Holds the I2C engine in reset |
| irqMask | output | 1 | Masks the I2C engine interrupts |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| success | output | 1 | Last run ended with both lines high |
| sclStuck | output | 1 | SCL read low when the last run was accepted |
| reinitReq | output | 1 | One-cycle request to re-initialise the engine |

## Verification
The bench models a target that releases SDA after a chosen number of SCL rising edges, K, drawn from 0 to 11. The patterns are chosen to tell apart the stopping rules:
- K = 0 shows that one pulse is always sent.
- K from 1 to 8 shows the early stop.
- K = 9 shows success on the last permitted pulse.
- K above 9 shows give-up without success.

A second pattern holds SCL low from outside. Held for the whole run, it sets the stuck flag and forces all nine pulses with no success. Released shortly after the start, it still sets the stuck flag but lets the recovery succeed. Start requests placed in the middle of a run show that the run length and the single done pulse are unchanged.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_LOW,
    ST_HIGH,
    ST_FINISH
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic own;
    logic drvLow;
    logic timerLoad;
    logic cntClr;
    logic cntInc;
    logic capStuck;
    logic setOk;
    logic clrOk;
    logic finish;
  } ctrlT;

  // status from datapath to control
  typedef struct packed {
    logic timerZero;
    logic bothHigh;
    logic lastPulse;
  } statT;

endpackage

// File: rtl/busclr_dp.sv
module busclr_dp
  import busclr_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 250_000_000,
  parameter int unsigned PHASE_US    = 10,
  parameter int unsigned MAX_PULSES  = 9
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlT cmd,
  input  logic sclIn,
  input  logic sdaIn,
  output statT st,
  output logic sclDrvLow,
  output logic sdaDrvLow,
  output logic pinSel,
  output logic engReset,
  output logic irqMask,
  output logic done,
  output logic reinitReq,
  output logic success,
  output logic sclStuck
);

  localparam longint unsigned PHASE_CYC_L =
    (64'(CLK_FREQ_HZ) * 64'(PHASE_US) + 64'd999_999) / 64'd1_000_000;
  localparam int unsigned PHASE_CYC = (PHASE_CYC_L < 1) ? 1 : int'(PHASE_CYC_L);
  localparam int unsigned TW = $clog2(PHASE_CYC + 1);
  localparam int unsigned CW = $clog2(MAX_PULSES + 1);
  localparam int unsigned SYNC_STAGES = 2;

  // two-flop synchronisers for both lines
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
    end
  end

  // bit 0 = SCL, bit 1 = SDA
  logic [1:0] pinsNow;
  assign pinsNow = {sdaSync[SYNC_STAGES-1], sclSync[SYNC_STAGES-1]};

  // phase down-counter
  logic [TW-1:0] phaseTimer;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseTimer <= '0;
    else if (cmd.timerLoad)    phaseTimer <= TW'(PHASE_CYC - 1);
    else if (phaseTimer != '0) phaseTimer <= phaseTimer - 1'b1;
  end

  // pulse counter
  logic [CW-1:0] pulseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pulseCnt <= '0;
    else if (cmd.cntClr) pulseCnt <= '0;
    else if (cmd.cntInc) pulseCnt <= pulseCnt + 1'b1;
  end

  // result flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclStuck <= 1'b0;
      success  <= 1'b0;
    end else begin
      if (cmd.capStuck) sclStuck <= ~pinsNow[0];
      if (cmd.clrOk)      success <= 1'b0;
      else if (cmd.setOk) success <= 1'b1;
    end
  end

  assign st.timerZero = (phaseTimer == '0);
  assign st.bothHigh  = (pinsNow == 2'b11);
  assign st.lastPulse = (pulseCnt == CW'(MAX_PULSES));

  assign sclDrvLow = cmd.drvLow;
  assign sdaDrvLow = 1'b0;
  assign pinSel    = cmd.own;
  assign engReset  = cmd.own;
  assign irqMask   = cmd.own;
  assign done      = cmd.finish;
  assign reinitReq = cmd.finish;

  // checker counter for the pulled-low phase length
  logic [TW:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lowRun <= '0;
    else if (cmd.drvLow) lowRun <= lowRun + 1'b1;
    else                 lowRun <= '0;
  end

  a_r4_pulse_limit: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CW'(MAX_PULSES));

  a_r5_low_length: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.drvLow && lowRun != '0) |-> (lowRun == (TW+1)'(PHASE_CYC)));

  a_r1_stuck_holds: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.capStuck |=> $stable(sclStuck));

  a_r8_success_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.clrOk && !cmd.setOk) |=> $stable(success));

endmodule

// File: rtl/busclr_ctrl.sv
module busclr_ctrl
  import busclr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  statT st,
  output ctrlT cmd,
  output logic busy
);

  stateT state, stateNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

  always_comb begin
    cmd     = '0;
    stateNx = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          cmd.capStuck = 1'b1;
          cmd.clrOk    = 1'b1;
          cmd.cntClr   = 1'b1;
          stateNx      = ST_PREP;
        end
      end
      ST_PREP: begin
        cmd.own       = 1'b1;
        cmd.timerLoad = 1'b1;
        cmd.cntInc    = 1'b1;
        stateNx       = ST_LOW;
      end
      ST_LOW: begin
        cmd.own    = 1'b1;
        cmd.drvLow = 1'b1;
        if (st.timerZero) begin
          cmd.timerLoad = 1'b1;
          stateNx       = ST_HIGH;
        end
      end
      ST_HIGH: begin
        cmd.own = 1'b1;
        if (st.timerZero) begin
          if (st.bothHigh) begin
            cmd.setOk = 1'b1;
            stateNx   = ST_FINISH;
          end else if (st.lastPulse) begin
            stateNx = ST_FINISH;
          end else begin
            cmd.timerLoad = 1'b1;
            cmd.cntInc    = 1'b1;
            stateNx       = ST_LOW;
          end
        end
      end
      ST_FINISH: begin
        cmd.finish = 1'b1;
        stateNx    = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_PREP) || (state == ST_LOW) || (state == ST_HIGH);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    cmd.finish |=> (!cmd.finish && !busy));

  a_r6_early_stop: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH && st.timerZero && st.bothHigh) |=> cmd.finish);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> !cmd.capStuck);

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import busclr_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 250_000_000,
  parameter int unsigned PHASE_US    = 10,
  parameter int unsigned MAX_PULSES  = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclDrvLow,
  output logic sdaDrvLow,
  output logic pinSel,
  output logic engReset,
  output logic irqMask,
  output logic busy,
  output logic done,
  output logic success,
  output logic sclStuck,
  output logic reinitReq
);

  ctrlT cmd;
  statT st;

  busclr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .st       (st),
    .cmd      (cmd),
    .busy     (busy)
  );

  busclr_dp #(
    .CLK_FREQ_HZ (CLK_FREQ_HZ),
    .PHASE_US    (PHASE_US),
    .MAX_PULSES  (MAX_PULSES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .st        (st),
    .sclDrvLow (sclDrvLow),
    .sdaDrvLow (sdaDrvLow),
    .pinSel    (pinSel),
    .engReset  (engReset),
    .irqMask   (irqMask),
    .done      (done),
    .reinitReq (reinitReq),
    .success   (success),
    .sclStuck  (sclStuck)
  );

  a_r2_owned_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (pinSel && engReset && irqMask));

  a_r3_sda_released: assert property (@(posedge clk) disable iff (!rstN)
    !sdaDrvLow);

  a_r7_pins_returned: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!pinSel && !engReset && !busy && reinitReq));

endmodule

// File: tb/sim_i2c_bus_clear.sv
module sim_i2c_bus_clear;

  localparam int unsigned FREQ = 2_000_000;
  localparam int P = 20;   // ceil(2e6 * 10e-6)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic sclHold = 1'b0;
  int   sdaNeed = 0;
  int   riseBase = 0;
  int   sclRises = 0;
  logic prevScl = 1'b1;

  logic sclDrvLow, sdaDrvLow, pinSel, engReset, irqMask;
  logic busy, done, success, sclStuck, reinitReq;
  logic sclLine, sdaLine;

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign sclLine = !(sclDrvLow || sclHold);
  assign sdaLine = ((sclRises - riseBase) >= sdaNeed);

  always @(posedge clk) begin
    prevScl <= sclLine;
    if (sclLine && !prevScl) sclRises <= sclRises + 1;
  end

  i2c_bus_clear #(.CLK_FREQ_HZ(FREQ)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .pinSel(pinSel),
    .engReset(engReset), .irqMask(irqMask), .busy(busy), .done(done),
    .success(success), .sclStuck(sclStuck), .reinitReq(reinitReq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expPulses(input int k, input bit holdAll);
    if (holdAll) return 9;
    if (k == 0)  return 1;
    if (k > 9)   return 9;
    return k;
  endfunction

  function automatic bit expOk(input int k, input bit holdAll);
    return !holdAll && (k <= 9);
  endfunction

  // k: rising edges the target needs; holdAll: SCL held low by outside all run;
  // holdShort: SCL held low only at start; extraAt: cycle of a stray start (-1 none)
  task automatic runOnce(input int k, input bit holdAll, input bit holdShort, input int extraAt);
    int pulses = 0, curLow = 0, highCnt = 0;
    int lowBad = 0, highBad = 0, ownBad = 0, sdaBad = 0, doneCnt = 0, reinBad = 0;
    int lastLowEnd = 0;
    bit gotDone = 0;
    int retrig = 0;
    sclHold  = holdAll || holdShort;
    sdaNeed  = k;
    riseBase = sclRises;
    repeat (6) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int c = 0; c < 3000 && !gotDone; c++) begin
      if (done) begin
        gotDone = 1;
        doneCnt++;
        if (!reinitReq) reinBad++;
        if (pinSel || engReset || irqMask || busy) ownBad++;
        if (highCnt != P) highBad++;
      end else if (busy) begin
        if (!(pinSel && engReset && irqMask)) ownBad++;
        if (sclDrvLow) begin
          if (curLow == 0) begin
            pulses++;
            if (pulses > 1 && highCnt != P) highBad++;
          end
          curLow++;
          highCnt = 0;
        end else begin
          if (curLow > 0 && curLow != P) lowBad++;
          curLow = 0;
          if (pulses > 0) highCnt++;
        end
      end else begin
        ownBad++;
      end
      if (sdaDrvLow) sdaBad++;
      if (holdShort && c == 3) sclHold = 1'b0;
      startReq = (c == extraAt);
      @(negedge clk);
    end
    startReq = 1'b0;
    for (int c = 0; c < 30; c++) begin
      if (busy || done || pinSel || sclDrvLow) retrig++;
      if (sdaDrvLow) sdaBad++;
      @(negedge clk);
    end
    sclHold = 1'b0;
    chk(gotDone && doneCnt == 1, "R7 single done", doneCnt, 1);
    chk(reinBad == 0, "R7 reinit with done", reinBad, 0);
    chk(ownBad == 0, "R2 pin ownership", ownBad, 0);
    chk(pulses == expPulses(k, holdAll), "R4/R6 pulse count", pulses, expPulses(k, holdAll));
    chk(lowBad == 0 && highBad == 0, "R5 phase length", lowBad + highBad, 0);
    chk(sdaBad == 0, "R3 SDA never driven", sdaBad, 0);
    chk(success == expOk(k, holdAll), "R8 success", success, expOk(k, holdAll));
    chk(sclStuck == (holdAll || holdShort), "R1 stuck flag", sclStuck, holdAll || holdShort);
    if (extraAt >= 0)
      chk(retrig == 0, "R9 start ignored while busy", retrig, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150_000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!sclDrvLow && !sdaDrvLow && !pinSel && !engReset && !irqMask && !busy &&
        !done && !success && !sclStuck && !reinitReq, "R10 reset outputs", 1, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !pinSel && !engReset && !irqMask && !sclDrvLow, "R2 idle outputs", busy, 0);
    // directed corners
    runOnce(0, 0, 0, -1);    // R6 one pulse minimum
    runOnce(3, 0, 0, 30);    // R6 early stop, R9 stray start
    runOnce(9, 0, 0, -1);    // R8 success on last pulse
    runOnce(10, 0, 0, -1);   // R4 give up
    runOnce(2, 1, 0, 100);   // R1 stuck all run, R9
    runOnce(4, 0, 1, -1);    // R1 stuck at entry, still succeeds
    // random mix
    for (int i = 0; i < 10; i++) begin
      int k = int'($urandom_range(0, 11));
      bit h = ($urandom_range(0, 4) == 0);
      runOnce(k, h, 0, ($urandom_range(0, 1) == 1) ? 25 : -1);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule